// File: doc/BRIEF.md
# Prioritized Interrupt Collector

This block gathers level-sensitive request lines from up to 127 sources and folds them into a single processor interrupt. Each source owns a small control word holding an enable flag and a priority level. Among sources that are enabled, pending and not blocked by service already in progress, the collector picks the one to present. The interrupt line and a status register report the number of that source, and the status register reads back a reserved idle code when no source qualifies.

Software drives the block through a simple word-wide register port. The usual handler loop reads the status register. If the value is not the idle code, it writes that number to the vector register, which puts the source's priority level in service, and runs the source's handler. It repeats until status reads idle. When it is done with a level, it writes a one-hot code to the level-acknowledge register to release that level. A write with the top bit set to the control register returns every source and all service state to the reset condition.

Top module: `icol_top`

## Requirements
- R1: After reset, `irq_o` is 0, `sel_o` and a status read both give 0x7f, and every per-source register reads 0.
- R2: The register for source n is at 0x120 + 16*n and holds priority in bits 1:0 and enable in bit 2. A write at +0x0 replaces both fields. A write at +0x4 ORs in the written ones, and a write at +0x8 clears the written ones. Reads at all three addresses return the same value, with bits 31:3 reading 0.
- R3: Each request input passes through two flip-flops before arbitration. A request rising just before clock edge k is first seen on `irq_o` after edge k+1.
- R4: A source whose enable is 0 never raises `irq_o` and is never reported.
- R5: Among eligible sources, the higher priority value wins. When priorities are equal, the lowest-numbered source wins.
- R6: A read at 0x070 (status) or 0x000 (vector) returns the selected source number in bits 6:0, or 0x7f when none is selected. `sel_o` carries the same code, and `irq_o` is 1 exactly when it is not 0x7f.
- R7: A write of a source number below N_SRC to 0x000 puts that source's current priority level in service. From the next cycle, sources at that level or below are not presented.
- R8: A write to 0x010 with bit k set releases level k from service. Levels whose bits are written as 0 keep their state.
- R9: While a level is in service, an eligible source at a strictly higher level is still presented.
- R10: A write to 0x020 with bit 31 set clears every enable, every priority and all in-service state. A write there with bit 31 clear has no effect.
- R11: A vector write with a value of N_SRC or more changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_SRC | Level-sensitive request lines, asynchronous to `clk_i` |
| bus_we_i | input | 1 | Write strobe, one word per cycle |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Interrupt to the processor |
| sel_o | output | 7 | Number of the selected source, 0x7f when idle |

## Verification
The assertions take for granted that the register port carries at most one write per cycle. They also assume that a vector or acknowledge write never coincides with a soft-reset write, so that each cycle's change to the service state has a single cause. The bench keeps to this by issuing every register access through one task that drives a single write strobe per cycle. It waits three clocks after each change of `req_i` before comparing, so the two synchronizer stages have settled. The random phase draws requests, per-source writes through all three aliases, vector writes and one-hot acknowledges from a seeded generator, and it compares the result against a reference model built from the requirements.

// File: rtl/icol_pkg.sv
package icol_pkg;
   localparam int unsigned DATA_W     = 32;
   localparam int unsigned SEL_W      = 7;
   localparam logic [6:0]  IDLE_CODE  = 7'h7f;
   localparam int unsigned OFF_VEC    = 'h000;
   localparam int unsigned OFF_ACK    = 'h010;
   localparam int unsigned OFF_CTRL   = 'h020;
   localparam int unsigned OFF_STAT   = 'h070;
   localparam int unsigned OFF_SRC    = 'h120;
   localparam int unsigned SRC_STRIDE = 'h10;
   localparam int unsigned EN_BIT     = 2;
   localparam int unsigned SRST_BIT   = 31;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_BASE = 2'd1,
      ACC_SET  = 2'd2,
      ACC_CLR  = 2'd3
   } src_acc_e;
endpackage

// File: rtl/icol_sync.sv
module icol_sync #(
   parameter int unsigned W      = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("icol_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            stage_q[s] <= '0;
         end else begin
            if (s == 0) stage_q[s] <= d_i;
            else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/icol_srcreg.sv
module icol_srcreg
   import icol_pkg::*;
#(
   parameter int unsigned N_SRC = 16,
   parameter int unsigned LVL_W = 2,
   parameter int unsigned IDX_W = 4
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   srst_i,
   input  src_acc_e               acc_i,
   input  logic [IDX_W-1:0]       idx_i,
   input  logic                   en_bit_i,
   input  logic [LVL_W-1:0]       pr_bits_i,
   output logic [N_SRC-1:0]       en_o,
   output logic [N_SRC*LVL_W-1:0] pr_o
);
   logic [LVL_W-1:0] pr_q [N_SRC];

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      logic hit;
      assign hit = (idx_i == IDX_W'(g));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            en_o[g] <= 1'b0;
            pr_q[g] <= '0;
         end else if (srst_i) begin
            en_o[g] <= 1'b0;
            pr_q[g] <= '0;
         end else if (hit) begin
            unique case (acc_i)
               ACC_BASE: begin
                  en_o[g] <= en_bit_i;
                  pr_q[g] <= pr_bits_i;
               end
               ACC_SET: begin
                  en_o[g] <= en_o[g] | en_bit_i;
                  pr_q[g] <= pr_q[g] | pr_bits_i;
               end
               ACC_CLR: begin
                  en_o[g] <= en_o[g] & ~en_bit_i;
                  pr_q[g] <= pr_q[g] & ~pr_bits_i;
               end
               default: ;
            endcase
         end
      end

      assign pr_o[g*LVL_W +: LVL_W] = pr_q[g];
   end
endmodule

// File: rtl/icol_arb.sv
module icol_arb #(
   parameter int unsigned N_SRC = 16,
   parameter int unsigned LVL_W = 2,
   parameter int unsigned IDX_W = 4,
   localparam int unsigned NLVL = 1 << LVL_W
) (
   input  logic [N_SRC-1:0]       pend_i,
   input  logic [N_SRC*LVL_W-1:0] pr_i,
   input  logic [NLVL-1:0]        isr_i,
   output logic                   found_o,
   output logic [IDX_W-1:0]       win_o
);
   logic [NLVL-1:0]  lvl_open;
   logic [N_SRC-1:0] elig;

   for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      assign lvl_open[l] = ~|(isr_i >> l);
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_elig
      assign elig[i] = pend_i[i] & lvl_open[pr_i[i*LVL_W +: LVL_W]];
   end

   always_comb begin
      logic [LVL_W-1:0] best_pr;
      found_o = 1'b0;
      win_o   = '0;
      best_pr = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (elig[i] && (!found_o || pr_i[i*LVL_W +: LVL_W] > best_pr)) begin
            found_o = 1'b1;
            best_pr = pr_i[i*LVL_W +: LVL_W];
            win_o   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/icol_top.sv
module icol_top
   import icol_pkg::*;
#(
   parameter int unsigned N_SRC  = 16,
   parameter int unsigned LVL_W  = 2,
   parameter int unsigned ADDR_W = 12,
   localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int unsigned NLVL  = 1 << LVL_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [N_SRC-1:0]  req_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic              irq_o,
   output logic [6:0]        sel_o
);
   if (N_SRC < 1 || N_SRC > 127) begin : g_bad_nsrc
      $error("icol_top: N_SRC must lie in 1..127");
   end
   if (LVL_W < 1 || LVL_W > 2) begin : g_bad_lvl
      $error("icol_top: LVL_W must be 1 or 2");
   end
   if (OFF_SRC + N_SRC * SRC_STRIDE > (1 << ADDR_W)) begin : g_bad_addr
      $error("icol_top: ADDR_W too narrow for the source window");
   end

   logic [N_SRC-1:0]       req_s;
   logic [N_SRC-1:0]       en_q;
   logic [N_SRC*LVL_W-1:0] pr_flat;
   logic [NLVL-1:0]        isr_q;
   logic                   found;
   logic [IDX_W-1:0]       win;

   // address decode
   logic [ADDR_W-1:0] rel;
   logic              src_hit;
   logic [IDX_W-1:0]  src_idx;
   src_acc_e          kind, wr_kind;
   logic              is_vec, is_ack, is_ctrl, is_stat;

   assign rel     = bus_addr_i - ADDR_W'(OFF_SRC);
   assign src_hit = (32'(bus_addr_i) >= OFF_SRC) &&
                    (32'(bus_addr_i) < OFF_SRC + N_SRC * SRC_STRIDE);
   assign src_idx = IDX_W'(rel >> 4);
   assign is_vec  = (bus_addr_i == ADDR_W'(OFF_VEC));
   assign is_ack  = (bus_addr_i == ADDR_W'(OFF_ACK));
   assign is_ctrl = (bus_addr_i == ADDR_W'(OFF_CTRL));
   assign is_stat = (bus_addr_i == ADDR_W'(OFF_STAT));

   always_comb begin
      kind = ACC_NONE;
      if (src_hit) begin
         unique case (rel[3:0])
            4'h0:    kind = ACC_BASE;
            4'h4:    kind = ACC_SET;
            4'h8:    kind = ACC_CLR;
            default: kind = ACC_NONE;
         endcase
      end
   end
   assign wr_kind = bus_we_i ? kind : ACC_NONE;

   // write strobes
   logic             srst;
   logic             vec_ok;
   logic [IDX_W-1:0] vec_idx;
   logic [LVL_W-1:0] vec_lvl;

   assign srst    = bus_we_i && is_ctrl && bus_wdata_i[SRST_BIT];
   assign vec_ok  = bus_we_i && is_vec && (bus_wdata_i < N_SRC);
   assign vec_idx = IDX_W'(bus_wdata_i);
   assign vec_lvl = pr_flat[vec_idx*LVL_W +: LVL_W];

   icol_sync #(.W(N_SRC), .STAGES(2)) sync_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (req_i),
      .q_o   (req_s)
   );

   icol_srcreg #(.N_SRC(N_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) srcreg_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .srst_i   (srst),
      .acc_i    (wr_kind),
      .idx_i    (src_idx),
      .en_bit_i (bus_wdata_i[EN_BIT]),
      .pr_bits_i(bus_wdata_i[LVL_W-1:0]),
      .en_o     (en_q),
      .pr_o     (pr_flat)
   );

   icol_arb #(.N_SRC(N_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) arb_i (
      .pend_i (req_s & en_q),
      .pr_i   (pr_flat),
      .isr_i  (isr_q),
      .found_o(found),
      .win_o  (win)
   );

   // in-service levels
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         isr_q <= '0;
      end else if (srst) begin
         isr_q <= '0;
      end else if (vec_ok) begin
         isr_q <= isr_q | (NLVL'(1) << vec_lvl);
      end else if (bus_we_i && is_ack) begin
         isr_q <= isr_q & ~bus_wdata_i[NLVL-1:0];
      end
   end

   assign irq_o = found;
   assign sel_o = found ? SEL_W'(win) : IDLE_CODE;

   // read mux
   logic [1:0] pr_rd;
   assign pr_rd = 2'(pr_flat[src_idx*LVL_W +: LVL_W]);

   always_comb begin
      bus_rdata_o = '0;
      if (is_vec || is_stat) begin
         bus_rdata_o = {25'd0, sel_o};
      end else if (kind != ACC_NONE) begin
         bus_rdata_o = {29'd0, en_q[src_idx], pr_rd};
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^{bus_wdata_i[30:EN_BIT+1], is_ctrl};
endmodule

// File: rtl/icol_chk.sv
module icol_chk #(
   parameter int unsigned N_SRC  = 16,
   parameter int unsigned LVL_W  = 2,
   parameter int unsigned ADDR_W = 12,
   localparam int unsigned NLVL  = 1 << LVL_W,
   localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic                   bus_we_i,
   input logic [ADDR_W-1:0]      bus_addr_i,
   input logic [31:0]            bus_wdata_i,
   input logic                   irq_o,
   input logic [6:0]             sel_o,
   input logic [N_SRC-1:0]       en_q,
   input logic [N_SRC-1:0]       req_s,
   input logic [NLVL-1:0]        isr_q,
   input logic [N_SRC*LVL_W-1:0] pr_flat
);
   logic             sel_live;
   logic             vec_hit, ack_hit, srst_hit;
   logic [LVL_W-1:0] vlvl;

   always_comb begin
      sel_live = 1'b0;
      if (32'(sel_o) < N_SRC) sel_live = en_q[IDX_W'(sel_o)] & req_s[IDX_W'(sel_o)];
   end

   assign vec_hit  = bus_we_i && (bus_addr_i == '0) && (bus_wdata_i < N_SRC);
   assign ack_hit  = bus_we_i && (bus_addr_i == ADDR_W'('h010));
   assign srst_hit = bus_we_i && (bus_addr_i == ADDR_W'('h020)) && bus_wdata_i[31];
   assign vlvl     = pr_flat[IDX_W'(bus_wdata_i)*LVL_W +: LVL_W];

   AST_IDLE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_o |-> sel_o == 7'h7f);  // R6

   AST_ONLY_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> sel_live);  // R4

   AST_VEC_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_hit |=> isr_q[$past(vlvl)]);  // R7

   AST_ACK_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_hit |=> (isr_q & $past(bus_wdata_i[NLVL-1:0])) == '0);  // R8

   AST_SOFT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst_hit |=> !irq_o && isr_q == '0 && en_q == '0);  // R10
endmodule

bind icol_top icol_chk #(.N_SRC(N_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .bus_we_i   (bus_we_i),
   .bus_addr_i (bus_addr_i),
   .bus_wdata_i(bus_wdata_i),
   .irq_o      (irq_o),
   .sel_o      (sel_o),
   .en_q       (en_q),
   .req_s      (req_s),
   .isr_q      (isr_q),
   .pr_flat    (pr_flat)
);

// File: tb/icol_top_tb.sv
module icol_top_tb_top;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic        we = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   logic [6:0]  sel;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   // reference model
   bit       m_en [N];
   bit [1:0] m_pr [N];
   bit [3:0] m_isr;

   always #5 clk = ~clk;

   icol_top dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .bus_we_i(we),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .irq_o(irq), .sel_o(sel)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic void model_reset();
      for (int i = 0; i < N; i++) begin
         m_en[i] = 0;
         m_pr[i] = 0;
      end
      m_isr = 0;
   endfunction

   function automatic logic [6:0] exp_sel();
      int top = -1;
      int best = -1;
      for (int l = 0; l < 4; l++) if (m_isr[l]) top = l;
      for (int i = 0; i < N; i++)
         if (req[i] && m_en[i] && int'(m_pr[i]) > top)
            if (best < 0 || m_pr[i] > m_pr[best]) best = i;
      return (best < 0) ? 7'h7f : 7'(best);
   endfunction

   function automatic void model_wr(input logic [11:0] a, input logic [31:0] d);
      if (a == 12'h020 && d[31]) model_reset();
      else if (a == 12'h000 && d < N) m_isr[m_pr[d[3:0]]] = 1'b1;
      else if (a == 12'h010) m_isr = m_isr & ~d[3:0];
      else if (a >= 12'h120 && a < 12'h120 + 16 * N) begin
         int n = (int'(a) - 'h120) / 16;
         case (a[3:0])
            4'h0: begin m_en[n] = d[2];          m_pr[n] = d[1:0];          end
            4'h4: begin m_en[n] = m_en[n] | d[2]; m_pr[n] = m_pr[n] | d[1:0]; end
            4'h8: begin m_en[n] = m_en[n] & ~d[2]; m_pr[n] = m_pr[n] & ~d[1:0]; end
            default: ;
         endcase
      end
   endfunction

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
      model_wr(a, d);
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic set_req(input logic [N-1:0] v);
      @(negedge clk);
      req = v;
      repeat (3) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      void'($urandom(32'h1c0_11ec));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", 32'(irq), 0);
      check("R1 sel", 32'(sel), 32'h7f);
      rd(12'h070, d); check("R1 status", d, 32'h7f);
      rd(12'h150, d); check("R1 src3 reg", d, 0);

      // R2 aliases
      wr(12'h150, 32'h6);         rd(12'h150, d); check("R2 base write", d, 6);
      wr(12'h158, 32'h4);         rd(12'h150, d); check("R2 clear alias", d, 2);
      rd(12'h154, d); check("R2 read at set alias", d, 2);
      wr(12'h154, 32'hFFFF_FFF5); rd(12'h158, d); check("R2 set alias, upper bits zero", d, 7);

      // R3 two-stage synchronizer
      @(negedge clk); req[3] = 1'b1;
      @(negedge clk); check("R3 one edge", 32'(irq), 0);
      @(negedge clk); check("R3 two edges", 32'(irq), 1);
      check("R3 sel", 32'(sel), 3);
      rd(12'h070, d); check("R6 status", d, 3);
      rd(12'h000, d); check("R6 vector read", d, 3);

      // R4 disabled sources
      set_req(req | 16'h0020);
      check("R4 disabled src5 ignored", 32'(sel), 3);
      wr(12'h158, 32'h4);
      check("R4 irq off", 32'(irq), 0);
      rd(12'h070, d); check("R4 status idle", d, 32'h7f);

      // R5 priority and tie break
      wr(12'h170, 32'h5);
      wr(12'h1B0, 32'h5);
      set_req(req | 16'h0200);
      check("R5 tie lowest index", 32'(sel), 5);
      wr(12'h1E0, 32'h6);
      set_req(req | 16'h1000);
      check("R5 higher level wins", 32'(sel), 12);

      // R7 vector write masks level 2 and below
      wr(12'h000, 32'd12);
      check("R7 masked sel", 32'(sel), 32'h7f);
      check("R7 masked irq", 32'(irq), 0);

      // R8 acknowledge of another level leaves level 2
      wr(12'h010, 32'h2);
      check("R8 other level kept", 32'(sel), 32'h7f);

      // R9 higher level still presented
      wr(12'h154, 32'h4);
      check("R9 level3 over level2", 32'(sel), 3);
      wr(12'h158, 32'h4);

      // R8 release level 2
      wr(12'h010, 32'h4);
      check("R8 release", 32'(sel), 12);

      // R11 out of range vector
      wr(12'h000, 32'd28);
      check("R11 ignored", 32'(sel), 12);

      // R10 soft reset
      wr(12'h020, 32'h7FFF_FFFF);
      check("R10 bit31 clear no effect", 32'(sel), 12);
      wr(12'h000, 32'd12);
      wr(12'h020, 32'h8000_0000);
      check("R10 sel idle", 32'(sel), 32'h7f);
      rd(12'h1E0, d); check("R10 reg cleared", d, 0);
      wr(12'h1E4, 32'h4);
      check("R10 service cleared", 32'(sel), 12);

      // random phase against the model
      wr(12'h020, 32'h8000_0000);
      set_req('0);
      for (int it = 0; it < 400; it++) begin
         int op = $urandom_range(0, 19);
         if (op < 5) begin
            set_req(N'($urandom));
         end else if (op < 12) begin
            int n = $urandom_range(0, N-1);
            int al = $urandom_range(0, 2);
            wr(12'(12'h120 + 16 * n + 4 * al), $urandom & 32'h7);
            rd(12'(12'h120 + 16 * n + 4 * $urandom_range(0, 2)), d);
            check("R2 random reg", d, {29'd0, m_en[n], m_pr[n]});
         end else if (op < 16) begin
            logic [6:0] s = exp_sel();
            wr(12'h000, (s == 7'h7f) ? $urandom_range(0, 31) : 32'(s));
         end else if (op < 19) begin
            wr(12'h010, 32'(1 << $urandom_range(0, 3)));
         end else begin
            wr(12'h020, 32'h8000_0000);
         end
         check("R5 random sel", 32'(sel), 32'(exp_sel()));
         check("R6 random irq", 32'(irq), 32'(exp_sel() != 7'h7f));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule